// File: doc/BRIEF.md
# Dual-Engine Display Timing Generator

This block produces the raster timing for two display engines that step together. A dot prescaler divides the clock into dot periods. A line sequencer counts dots inside a line and lines inside a frame. Each engine keeps its own status: a horizontal-blank flag, a vertical-blank flag, a line count, and a coincidence flag. The coincidence flag compares the line number with a compare value that software can write.

The line sequencer is a two-state machine. `PH_ACTIVE` covers the drawn dots of a line. When the last active dot ends, the *end-of-active* transition moves it to `PH_HBLANK`. When the last blanking dot ends, the *line-advance* transition moves it back to `PH_ACTIVE`. On a line advance the line counter steps forward, wrapping to zero after the last line. At the same edge every engine refreshes its flags.

The sequencer also drives two one-cycle strobes. The first tells a renderer that a visible line has started. The second tells the frame-buffer logic to swap buffers when vertical blanking begins. A renderer and a frame-buffer controller sit downstream of this block, and compare values are written through a simple write-enable port.

Top module: `dual_disp_timing`

## Requirements
- R1: While reset is held and directly after reset, `dot_count` and every line count are 0. All hblank, vblank and coincidence flags are low. `draw_start` and `buf_swap` are low.
- R2: The dot counter advances once every `CLK_PER_DOT` clocks. It runs from 0 to 354, then returns to 0, so a line has 256 active dots followed by 99 blanking dots.
- R3: An engine's hblank flag rises at the end-of-active transition, so it reads 1 for dots 256 to 354. It clears at the line advance.
- R4: Each line count increments by one at the line advance, which is the end of dot 354. It counts modulo 263, so line 262 is followed by line 0.
- R5: An engine's vblank flag is set on entering line 192 and cleared on entering line 262. It therefore reads 1 for lines 192 to 261 only.
- R6: `buf_swap` is high for exactly one clock: the first clock of line 192.
- R7: `draw_start` is high for one clock at the first clock of each line from 0 to 191 that is entered by a line advance. The line 0 that follows reset gets no strobe.
- R8: At every line advance, an engine's coincidence flag becomes (new line == that engine's compare value). The compare value used is the one held before the advancing edge. Between advances the flag does not change, whatever is written to the compare register.
- R9: Both engines show identical line counts, hblank flags and vblank flags on every cycle.
- R10: Each engine has a 9-bit compare register, reset to 0. Bit e of `cmp_wr_en` loads `cmp_wr_data` into engine e's register at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_wr_en | input | NUM_ENGINES | Per-engine compare register write enable |
| cmp_wr_data | input | LINE_W | Compare value to load |
| hblank | output | NUM_ENGINES | Per-engine horizontal-blank flag |
| vblank | output | NUM_ENGINES | Per-engine vertical-blank flag |
| coincide | output | NUM_ENGINES | Per-engine line-compare coincidence flag |
| line_count | output | NUM_ENGINES*LINE_W | Per-engine line count, engine e in bits [e*LINE_W +: LINE_W] |
| dot_count | output | DOT_W | Dot position within the line |
| draw_start | output | 1 | One-clock strobe at the start of a visible line |
| buf_swap | output | 1 | One-clock strobe on entering vertical blanking |

## Verification
All outputs come straight from registers. Each result therefore shows from the clock edge on which its event happens: the end-of-active edge for hblank, and the line-advance edge for the line counts, vblank, coincidence and both strobes. The bench works out, from the number of edges since reset release, which edge last ticked and which dot and line it produced. It samples every output on the falling edge that follows, so each value is checked in the cycle it is due.

A compare write that is driven before an edge lands on that edge. The bench keeps a shadow of the compare register for each engine. On an advance edge it compares against the shadow value from before that edge. It also places some writes on the advance edge itself, to confirm that the value held before that edge is the one used.

// File: rtl/dual_disp_timing_pkg.sv
package dual_disp_timing_pkg;

    typedef enum logic [0:0] {
        PH_ACTIVE = 1'b0,
        PH_HBLANK = 1'b1
    } line_phase_e;

    typedef struct packed {
        logic hdraw_end;
        logic line_adv;
    } line_evt_t;

endpackage

// File: rtl/dtg_dot_prescaler.sv
module dtg_dot_prescaler #(
    parameter int CLK_PER_DOT = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic dot_tick
);
    localparam int CW = (CLK_PER_DOT > 1) ? $clog2(CLK_PER_DOT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_DOT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign dot_tick = (cnt_q == LAST);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CLK_PER_DOT > 1 && dot_tick) |=> !dot_tick);

endmodule

// File: rtl/dtg_line_sequencer.sv
module dtg_line_sequencer
    import dual_disp_timing_pkg::*;
#(
    parameter int ACTIVE_DOTS   = 256,
    parameter int HBLANK_DOTS   = 99,
    parameter int VISIBLE_LINES = 192,
    parameter int TOTAL_LINES   = 263,
    parameter int LINE_W        = 9,
    parameter int DOT_W         = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_tick,
    output logic [DOT_W-1:0]  dot_count,
    output logic [LINE_W-1:0] line_count,
    output line_evt_t         evt,
    output logic              draw_start,
    output logic              buf_swap
);
    localparam int LINE_DOTS = ACTIVE_DOTS + HBLANK_DOTS;
    localparam logic [DOT_W-1:0]  LAST_ACT  = DOT_W'(ACTIVE_DOTS - 1);
    localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(LINE_DOTS - 1);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);
    localparam logic [LINE_W-1:0] VIS_LINE  = LINE_W'(VISIBLE_LINES);

    line_phase_e       phase_q, phase_d;
    logic [DOT_W-1:0]  dot_q;
    logic [LINE_W-1:0] line_q, line_nxt;
    logic              draw_q, swap_q;

    // next-state and event decode
    always_comb begin
        phase_d = phase_q;
        evt     = '0;
        unique case (phase_q)
            PH_ACTIVE: begin
                if (dot_tick && dot_q == LAST_ACT) begin
                    phase_d       = PH_HBLANK;
                    evt.hdraw_end = 1'b1;
                end
            end
            PH_HBLANK: begin
                if (dot_tick && dot_q == LAST_DOT) begin
                    phase_d      = PH_ACTIVE;
                    evt.line_adv = 1'b1;
                end
            end
            default: phase_d = PH_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= PH_ACTIVE;
        else
            phase_q <= phase_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dot_q <= '0;
        else if (dot_tick)
            dot_q <= (dot_q == LAST_DOT) ? '0 : dot_q + 1'b1;
    end

    assign line_nxt = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;

    // outputs: line counter and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            draw_q <= 1'b0;
            swap_q <= 1'b0;
        end else begin
            draw_q <= evt.line_adv && (line_nxt < VIS_LINE);
            swap_q <= evt.line_adv && (line_nxt == VIS_LINE);
            if (evt.line_adv)
                line_q <= line_nxt;
        end
    end

    assign dot_count  = dot_q;
    assign line_count = line_q;
    assign draw_start = draw_q;
    assign buf_swap   = swap_q;

    // R2
    dot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_tick |=> $stable(dot_q));
    // R3
    phase_hblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HBLANK) |-> (dot_q > LAST_ACT));
    // R4
    line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.line_adv && line_q == LAST_LINE) |=> (line_q == '0));
    // R6
    swap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_swap |=> !buf_swap);
    // R6
    swap_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_swap |-> (line_q == VIS_LINE && dot_q == '0));
    // R7
    draw_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        draw_start |-> (line_q < VIS_LINE && dot_q == '0));

endmodule

// File: rtl/dtg_engine_status.sv
module dtg_engine_status
    import dual_disp_timing_pkg::*;
#(
    parameter int VISIBLE_LINES = 192,
    parameter int TOTAL_LINES   = 263,
    parameter int LINE_W        = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_evt_t         evt,
    input  logic              cmp_we,
    input  logic [LINE_W-1:0] cmp_data,
    output logic              hblank,
    output logic              vblank,
    output logic              coincide,
    output logic [LINE_W-1:0] line_count
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);
    localparam logic [LINE_W-1:0] VIS_LINE  = LINE_W'(VISIBLE_LINES);

    logic [LINE_W-1:0] cmp_q, line_q, line_nxt;
    logic              hblank_q, vblank_q, coin_q;

    assign line_nxt = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (cmp_we)
            cmp_q <= cmp_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q   <= '0;
            hblank_q <= 1'b0;
            vblank_q <= 1'b0;
            coin_q   <= 1'b0;
        end else if (evt.line_adv) begin
            line_q   <= line_nxt;
            hblank_q <= 1'b0;
            coin_q   <= (line_nxt == cmp_q);
            if (line_nxt == VIS_LINE)
                vblank_q <= 1'b1;
            else if (line_nxt == LAST_LINE)
                vblank_q <= 1'b0;
        end else if (evt.hdraw_end) begin
            hblank_q <= 1'b1;
        end
    end

    assign hblank     = hblank_q;
    assign vblank     = vblank_q;
    assign coincide   = coin_q;
    assign line_count = line_q;

    // R3
    hblank_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.hdraw_end |=> hblank_q);
    // R8
    coin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.line_adv |=> $stable(coin_q));
    // R5
    vblank_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_q |-> (line_q >= VIS_LINE && line_q < LAST_LINE));

endmodule

// File: rtl/dual_disp_timing.sv
module dual_disp_timing
    import dual_disp_timing_pkg::*;
#(
    parameter int CLK_PER_DOT   = 1,
    parameter int NUM_ENGINES   = 2,
    parameter int ACTIVE_DOTS   = 256,
    parameter int HBLANK_DOTS   = 99,
    parameter int VISIBLE_LINES = 192,
    parameter int TOTAL_LINES   = 263,
    parameter int LINE_W        = 9,
    parameter int DOT_W         = $clog2(ACTIVE_DOTS + HBLANK_DOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_ENGINES-1:0]        cmp_wr_en,
    input  logic [LINE_W-1:0]             cmp_wr_data,
    output logic [NUM_ENGINES-1:0]        hblank,
    output logic [NUM_ENGINES-1:0]        vblank,
    output logic [NUM_ENGINES-1:0]        coincide,
    output logic [NUM_ENGINES*LINE_W-1:0] line_count,
    output logic [DOT_W-1:0]              dot_count,
    output logic                          draw_start,
    output logic                          buf_swap
);
    logic              dot_tick;
    line_evt_t         evt;
    logic [LINE_W-1:0] seq_line;

    dtg_dot_prescaler #(
        .CLK_PER_DOT (CLK_PER_DOT)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .dot_tick (dot_tick)
    );

    dtg_line_sequencer #(
        .ACTIVE_DOTS   (ACTIVE_DOTS),
        .HBLANK_DOTS   (HBLANK_DOTS),
        .VISIBLE_LINES (VISIBLE_LINES),
        .TOTAL_LINES   (TOTAL_LINES),
        .LINE_W        (LINE_W),
        .DOT_W         (DOT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dot_tick   (dot_tick),
        .dot_count  (dot_count),
        .line_count (seq_line),
        .evt        (evt),
        .draw_start (draw_start),
        .buf_swap   (buf_swap)
    );

    for (genvar e = 0; e < NUM_ENGINES; e++) begin : g_eng
        dtg_engine_status #(
            .VISIBLE_LINES (VISIBLE_LINES),
            .TOTAL_LINES   (TOTAL_LINES),
            .LINE_W        (LINE_W)
        ) u_stat (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt        (evt),
            .cmp_we     (cmp_wr_en[e]),
            .cmp_data   (cmp_wr_data),
            .hblank     (hblank[e]),
            .vblank     (vblank[e]),
            .coincide   (coincide[e]),
            .line_count (line_count[e*LINE_W +: LINE_W])
        );

        // R9
        engine_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            line_count[e*LINE_W +: LINE_W] == seq_line);
        // R9
        engine_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hblank[e] == hblank[0]) && (vblank[e] == vblank[0]));
    end

endmodule

// File: tb/dual_disp_timing_test.sv
module dual_disp_timing_test;
    localparam int NI = 2;
    localparam int LW = 9;
    localparam int ACT [NI] = '{256, 8};
    localparam int HBL [NI] = '{99, 3};
    localparam int VIS [NI] = '{192, 6};
    localparam int TOT [NI] = '{263, 9};
    localparam int CPD [NI] = '{1, 3};
    localparam int PER [NI] = '{613, 7};
    localparam int RUN = 263 * 355 + 800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]      we [NI];
    logic [LW-1:0]   wd [NI];
    logic [1:0]      hb [NI], vb [NI], co [NI];
    logic [2*LW-1:0] lc [NI];
    logic [8:0]      dc0;
    logic [3:0]      dc1;
    logic [8:0]      dcx [NI];
    logic            ds [NI], sw [NI];

    assign dcx[0] = dc0;
    assign dcx[1] = {5'b0, dc1};

    dual_disp_timing #(.CLK_PER_DOT(1)) uut (
        .clk(clk), .rst_n(rst_n), .cmp_wr_en(we[0]), .cmp_wr_data(wd[0]),
        .hblank(hb[0]), .vblank(vb[0]), .coincide(co[0]), .line_count(lc[0]),
        .dot_count(dc0), .draw_start(ds[0]), .buf_swap(sw[0]));

    dual_disp_timing #(.CLK_PER_DOT(3), .ACTIVE_DOTS(8), .HBLANK_DOTS(3),
                       .VISIBLE_LINES(6), .TOTAL_LINES(9)) uut_small (
        .clk(clk), .rst_n(rst_n), .cmp_wr_en(we[1]), .cmp_wr_data(wd[1]),
        .hblank(hb[1]), .vblank(vb[1]), .coincide(co[1]), .line_count(lc[1]),
        .dot_count(dc1), .draw_start(ds[1]), .buf_swap(sw[1]));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int shadow [NI][2];
    bit pend_en [NI][2];
    int pend_data [NI];
    bit exp_coin [NI][2];

    task automatic chk(input string req, input string what, input int i,
                       input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s inst%0d %s: actual %0d expected %0d", req, i, what, act, exp);
        end
    endtask

    task automatic model_step(input int i, input int n);
        int ld, fr, dots, p, ln, dt, nd, ndot;
        bit adv, nadv;
        logic [1:0] mask;
        int data;
        ld   = ACT[i] + HBL[i];
        fr   = ld * TOT[i];
        dots = n / CPD[i];
        p    = dots % fr;
        ln   = p / ld;
        dt   = p % ld;
        adv  = (n % CPD[i] == 0) && (dt == 0) && (dots > 0);
        // R8: compare value held before the advancing edge
        if (adv)
            for (int e = 0; e < 2; e++) exp_coin[i][e] = (ln == shadow[i][e]);
        // R10: writes land on the edge just passed
        for (int e = 0; e < 2; e++) begin
            if (pend_en[i][e]) shadow[i][e] = pend_data[i];
            pend_en[i][e] = 1'b0;
        end
        chk("R2", "dot_count", i, int'(dcx[i]), dt);
        for (int e = 0; e < 2; e++) begin
            chk("R4", "line_count", i, int'(lc[i][e*LW +: LW]), ln);
            chk("R3", "hblank", i, int'(hb[i][e]), int'(dt >= ACT[i]));
            chk("R5", "vblank", i, int'(vb[i][e]), int'(ln >= VIS[i] && ln < TOT[i] - 1));
            chk("R8", "coincide", i, int'(co[i][e]), int'(exp_coin[i][e]));
        end
        chk("R9", "engine line match", i, int'(lc[i][LW +: LW]), int'(lc[i][0 +: LW]));
        chk("R7", "draw_start", i, int'(ds[i]), int'(adv && ln < VIS[i]));
        chk("R6", "buf_swap", i, int'(sw[i]), int'(adv && ln == VIS[i]));
        // schedule compare writes for the next edge
        nd   = (n + 1) / CPD[i];
        ndot = (nd % fr) % ld;
        nadv = ((n + 1) % CPD[i] == 0) && (ndot == 0);
        mask = 2'b00;
        data = 0;
        if (n % PER[i] == 3) begin
            mask = ((n / PER[i]) % 3 == 0) ? 2'b01 : ((n / PER[i]) % 3 == 1) ? 2'b10 : 2'b11;
            data = (ln + 1 + (n / PER[i]) % 2) % TOT[i];
        end
        if (nadv && (ln % 5 == 0)) begin
            mask = 2'b01;
            data = (ln + 1) % TOT[i];
        end
        we[i] = mask;
        wd[i] = LW'(data);
        pend_en[i][0] = mask[0];
        pend_en[i][1] = mask[1];
        pend_data[i] = data;
    endtask

    initial begin
        for (int i = 0; i < NI; i++) begin
            we[i] = 2'b00;
            wd[i] = '0;
            pend_data[i] = 0;
            for (int e = 0; e < 2; e++) begin
                shadow[i][e] = 0;
                pend_en[i][e] = 1'b0;
                exp_coin[i][e] = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int i = 0; i < NI; i++) begin
            chk("R1", "reset dot_count", i, int'(dcx[i]), 0);
            chk("R1", "reset line_count", i, int'(lc[i]), 0);
            chk("R1", "reset hblank", i, int'(hb[i]), 0);
            chk("R1", "reset vblank", i, int'(vb[i]), 0);
            chk("R1", "reset coincide", i, int'(co[i]), 0);
            chk("R1", "reset draw_start", i, int'(ds[i]), 0);
            chk("R1", "reset buf_swap", i, int'(sw[i]), 0);
        end
        rst_n = 1'b1;
        for (int c = 1; c <= RUN; c++) begin
            @(negedge clk);
            for (int i = 0; i < NI; i++) model_step(i, c);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule